// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing controller of a byte-addressed serial memory. It watches the clock and data wires of a two-wire bus, sampled on a much faster system clock. It spots start and stop conditions and answers only to its own device address. That address is a fixed type code plus three bits taken from external select pins, so up to eight such slaves can share one bus.

In a write transfer the master sends a two-byte word address followed by data bytes. The data bytes are collected in a one-page holding buffer and handed to the storage back end as a burst of write strobes once the stop condition arrives. In a read transfer the block fetches bytes from the back end at its current address and shifts them out most significant bit first. It keeps sending while the master acknowledges each byte.

The serial data line is driven only through an open-drain pull-down enable. The back end, which may add write protection, sees a plain address, write data and write strobe.

Top module: `tw_mem_slave`

## Requirements
- R1: Until a start condition (data falling while clock is high) has been seen after reset or after the block has gone idle, bus traffic is ignored: no acknowledge is driven and nothing is written.
- R2: The first byte after a start is the device byte. Bits 7..4 must be 1010, bits 3..1 must equal the select pins S2..S0, and bit 0 chooses read (1) or write (0). On a match the block pulls data low through the ninth clock. On a mismatch it does not acknowledge and ignores the bus until the next start.
- R3: A stop condition (data rising while clock is high) releases the data line and returns the block to idle from any state.
- R4: In a write transfer the two bytes after the device byte form the word address, high byte first. Only the low ADDR_W bits are kept. Every address and data byte is acknowledged on its ninth clock.
- R5: Data bytes of a write are held in a PAGE_BYTES buffer and written to the back end only after the stop. Each held byte produces one mem_we pulse with its own address and data, in ascending address order, while the block is idle.
- R6: Successive write bytes step the low log2(PAGE_BYTES) address bits, wrapping within the page with the upper bits fixed. A later byte that lands on the same location replaces the earlier one.
- R7: In a read transfer the block sends the back-end byte at the current address, most significant bit first, and then advances the address by one. After a master acknowledge it sends the next byte.
- R8: After a master no-acknowledge the block stops driving data and ignores further clocks until a start.
- R9: The read address wraps from the last location (all ones in ADDR_W bits) to zero.
- R10: A repeated start before any stop discards the write bytes held so far. The address they advanced is kept, so a dummy write sets the address for a following read.
- R11: Out of reset the data line is released and no write strobe is active.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sel_pins | input | 3 | Device select pins S2..S0 |
| mem_rdata | input | 8 | Back-end read data for mem_addr (combinational) |
| sda_oe | output | 1 | Pull data line low when 1 (open drain) |
| mem_addr | output | ADDR_W | Back-end address: flush address while writing, else the current pointer |
| mem_wdata | output | 8 | Back-end write data |
| mem_we | output | 1 | Back-end write strobe, one cycle per byte |

## Verification
A wrong state in the transfer sequencer shows up at sda_oe within one bus clock. Depending on the fault, an acknowledge is missing or appears where none belongs, or a read bit is wrong. A wrong address pointer shows up later: in the first read byte of the next read, or in the flush addresses after the stop. Stale or misplaced page buffer contents appear only on the mem_we burst a few dozen system cycles after the stop. The bench therefore checks every acknowledge bit, every read byte and every flushed address and data value.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_AHI, ST_ACK_AHI, ST_ALO, ST_ACK_ALO,
    ST_WDAT, ST_ACK_W, ST_RDAT, ST_RACK
  } tw_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // device byte: type code, select bits, then direction bit
  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
  endfunction

endpackage

// File: rtl/tw_line_mon.sv
module tw_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_now
);
  // index SYNC_STAGES-1 is the synchronised value, SYNC_STAGES its previous copy
  logic [SYNC_STAGES:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_in};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_in};
    end
  end

  assign scl_s     = scl_p[SYNC_STAGES-1];
  assign scl_d     = scl_p[SYNC_STAGES];
  assign sda_now   = sda_p[SYNC_STAGES-1];
  assign sda_d     = sda_p[SYNC_STAGES];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_now;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_now;
endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [7:0]        st_data,
  input  logic              commit,
  output logic              fl_busy,
  output logic              fl_we,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_data
);
  localparam int PB   = $clog2(PAGE_BYTES);
  localparam int PG_W = ADDR_W - PB;

  logic [7:0]            buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PG_W-1:0]       page_q;
  logic [PB-1:0]         idx_q;
  logic                  busy_q;

  always_ff @(posedge clk) begin
    if (st_en) buf_q[st_addr[PB-1:0]] <= st_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      page_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == PB'(PAGE_BYTES - 1)) begin
        busy_q <= 1'b0;
        vld_q  <= '0;
      end
    end else if (commit && (|vld_q)) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (st_en) begin
      vld_q[st_addr[PB-1:0]] <= 1'b1;
      page_q                 <= st_addr[ADDR_W-1:PB];
    end
  end

  assign fl_busy = busy_q;
  assign fl_we   = busy_q & vld_q[idx_q];
  assign fl_addr = {page_q, idx_q};
  assign fl_data = buf_q[idx_q];
endmodule

// File: rtl/tw_proto.sv
module tw_proto
  import tw_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_now,
  input  logic [2:0]        sel,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] ptr,
  output logic              st_en,
  output logic [7:0]        st_data,
  output tw_state_e         state_o
);
  localparam int PB        = $clog2(PAGE_BYTES);
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS) + 1;
  localparam int HI_W      = ADDR_W - 8;

  tw_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shreg;
  logic [HI_W-1:0]  hi_q;
  logic             rw_q, mack_q;
  logic             byte_full, is_rx;

  function automatic logic [ADDR_W-1:0] step_in_page(input logic [ADDR_W-1:0] a);
    logic [PB-1:0] lo;
    lo = a[PB-1:0] + 1'b1;
    return {a[ADDR_W-1:PB], lo};
  endfunction

  function automatic logic [ADDR_W-1:0] step_seq(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  assign byte_full = (cnt == CNT_W'(BYTE_BITS));
  assign is_rx     = (state == ST_DEV) || (state == ST_AHI) ||
                     (state == ST_ALO) || (state == ST_WDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      hi_q   <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (is_rx) begin
        shreg <= {shreg[6:0], sda_now};
        if (!byte_full) cnt <= cnt + 1'b1;
      end else if (state == ST_RDAT && !byte_full) begin
        cnt <= cnt + 1'b1;
      end else if (state == ST_RACK) begin
        mack_q <= ~sda_now;
      end
    end else if (scl_fall) begin
      case (state)
        ST_DEV: if (byte_full) begin
          if (dev_match(shreg, sel)) begin
            state  <= ST_ACK_DEV;
            sda_oe <= 1'b1;
            rw_q   <= shreg[0];
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_AHI: if (byte_full) begin
          hi_q   <= shreg[HI_W-1:0];
          state  <= ST_ACK_AHI;
          sda_oe <= 1'b1;
        end
        ST_ALO: if (byte_full) begin
          ptr    <= {hi_q, shreg};
          state  <= ST_ACK_ALO;
          sda_oe <= 1'b1;
        end
        ST_WDAT: if (byte_full) begin
          ptr    <= step_in_page(ptr);
          state  <= ST_ACK_W;
          sda_oe <= 1'b1;
        end
        ST_ACK_DEV: begin
          cnt <= '0;
          if (rw_q) begin
            state  <= ST_RDAT;
            shreg  <= rd_data;
            sda_oe <= ~rd_data[7];
          end else begin
            state  <= ST_AHI;
            sda_oe <= 1'b0;
          end
        end
        ST_ACK_AHI: begin
          state  <= ST_ALO;
          cnt    <= '0;
          sda_oe <= 1'b0;
        end
        ST_ACK_ALO, ST_ACK_W: begin
          state  <= ST_WDAT;
          cnt    <= '0;
          sda_oe <= 1'b0;
        end
        ST_RDAT: begin
          if (byte_full) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
            ptr    <= step_seq(ptr);
          end else begin
            shreg  <= {shreg[6:0], 1'b0};
            sda_oe <= ~shreg[6];
          end
        end
        ST_RACK: begin
          if (mack_q) begin
            state  <= ST_RDAT;
            cnt    <= '0;
            shreg  <= rd_data;
            sda_oe <= ~rd_data[7];
          end else begin
            state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign st_en   = scl_fall && !start_evt && !stop_evt && (state == ST_WDAT) && byte_full;
  assign st_data = shreg;
  assign state_o = state;
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tw_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        sel_pins,
  input  logic [7:0]        mem_rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we
);
  logic scl_rise, scl_fall, start_evt, stop_evt, sda_now;
  logic st_en_w, fl_busy, fl_we;
  logic [7:0] st_data_w, fl_data;
  logic [ADDR_W-1:0] ptr_w, fl_addr;
  tw_state_e state_w;

  tw_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_now(sda_now)
  );

  tw_proto #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_now(sda_now),
    .sel(sel_pins), .rd_data(mem_rdata), .sda_oe(sda_oe), .ptr(ptr_w),
    .st_en(st_en_w), .st_data(st_data_w), .state_o(state_w)
  );

  tw_page_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .st_en(st_en_w),
    .st_addr(ptr_w), .st_data(st_data_w), .commit(stop_evt),
    .fl_busy(fl_busy), .fl_we(fl_we), .fl_addr(fl_addr), .fl_data(fl_data)
  );

  assign mem_addr  = fl_busy ? fl_addr : ptr_w;
  assign mem_wdata = fl_data;
  assign mem_we    = fl_we;
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk
  import tw_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input tw_state_e         state,
  input logic              sda_oe,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              st_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] ptr
);
  localparam int PB = $clog2(PAGE_BYTES);

  // R8: an idle slave never pulls the data line
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R3: a stop releases the line and parks the sequencer
  a_r3_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && state == ST_IDLE));

  // R1: a start always leads into device-byte reception
  a_r1_start_to_dev: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_DEV));

  // R6: storing a write byte never changes the page part of the pointer
  a_r6_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |=> (ptr[ADDR_W-1:PB] == $past(ptr[ADDR_W-1:PB])));

  // R5: back-end writes happen only between transfers
  a_r5_we_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == ST_IDLE));
endmodule

bind tw_mem_slave tw_mem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_w), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .st_en(st_en_w),
  .mem_we(mem_we), .ptr(ptr_w)
);

// File: tb/sim_tw_mem_slave.sv
module sim_tw_mem_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 4;
  localparam int AW    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] sel = 3'b101;
  logic sda_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_line = m_sda & ~sda_oe;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction
  assign mem_rdata = pat(mem_addr);

  tw_mem_slave #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sel_pins(sel), .mem_rdata(mem_rdata), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  logic [AW-1:0] wl_a [64];
  logic [7:0]    wl_d [64];
  int wl_n = 0;
  always @(posedge clk) if (mem_we) begin
    if (wl_n < 64) begin
      wl_a[wl_n] <= mem_addr;
      wl_d[wl_n] <= mem_wdata;
    end
    wl_n <= wl_n + 1;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; hp(); m_scl = 1'b1; hp(); m_sda = 1'b0; hp(); m_scl = 1'b0; hp();
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; m_sda = 1'b0; hp(); m_scl = 1'b1; hp(); m_sda = 1'b1; hp();
  endtask

  task automatic clk_bit(input logic v, output logic s);
    m_sda = v; hp(); m_scl = 1'b1; hp(); s = sda_line; hp(); m_scl = 1'b0; hp();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    m_scl = 1'b0;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(!mack, s);
  endtask

  task automatic set_addr(input logic [15:0] a);
    logic k;
    bus_start();
    wbyte(8'hAA, k); chk("R2 write device ack", k, 1);
    wbyte(a[15:8], k); chk("R4 address high ack", k, 1);
    wbyte(a[7:0], k);  chk("R4 address low ack", k, 1);
  endtask

  task automatic t_reset();
    chk("R11 sda released after reset", sda_oe, 0);
    chk("R11 no write strobe after reset", mem_we, 0);
  endtask

  task automatic t_no_start();
    logic k;
    wbyte(8'hAA, k);
    chk("R1 no ack without start", k, 0);
  endtask

  task automatic t_select();
    logic k;
    bus_start(); wbyte(8'hA0, k); chk("R2 select mismatch no ack", k, 0);
    wbyte(8'h00, k); chk("R2 ignored after mismatch", k, 0); bus_stop();
    bus_start(); wbyte(8'hBA, k); chk("R2 type code mismatch no ack", k, 0); bus_stop();
    sel = 3'b000;
    bus_start(); wbyte(8'hA0, k); chk("R2 match on other select value", k, 1); bus_stop();
    sel = 3'b101;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_page_write();
    logic k; int b0; int acks;
    b0 = wl_n; acks = 0;
    set_addr(16'h0105);
    wbyte(8'h11, k); acks += int'(k);
    wbyte(8'h22, k); acks += int'(k);
    wbyte(8'h33, k); acks += int'(k);
    chk("R4 data bytes acked", acks, 3);
    chk("R5 nothing written before stop", wl_n - b0, 0);
    bus_stop();
    repeat (80) @(negedge clk);
    chk("R5 write count", wl_n - b0, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R5 write address", wl_a[b0+i], 12'h105 + i);
      chk("R5 write data", wl_d[b0+i], 8'h11 * (i + 1));
    end
  endtask

  task automatic t_page_wrap();
    logic k; int b0; int acks; int j;
    b0 = wl_n; acks = 0;
    set_addr(16'hF23E);  // R4: high bits beyond ADDR_W dropped -> 0x23E
    for (int n = 0; n < 34; n++) begin wbyte(8'h40 + 8'(n), k); acks += int'(k); end
    chk("R4 all page bytes acked", acks, 34);
    bus_stop();
    repeat (80) @(negedge clk);
    chk("R6 wrapped page write count", wl_n - b0, 32);
    for (int i = 0; i < 32; i++) begin
      j = (i - 30 + 32) % 32;
      if (j + 32 < 34) j += 32;
      chk("R6 wrapped address", wl_a[b0+i], 12'h220 + i);
      chk("R6 last byte wins", wl_d[b0+i], 8'h40 + j);
    end
  endtask

  task automatic t_random_read();
    logic k; int b0; logic [7:0] d;
    b0 = wl_n;
    set_addr(16'h07FD);
    wbyte(8'h99, k); wbyte(8'h98, k);
    bus_start();
    wbyte(8'hAB, k); chk("R2 read device ack", k, 1);
    rbyte(1'b1, d); chk("R7 read byte 0", d, pat(12'h7FF));
    rbyte(1'b1, d); chk("R7 read byte 1", d, pat(12'h800));
    rbyte(1'b0, d); chk("R7 read byte 2", d, pat(12'h801));
    bus_stop();
    repeat (80) @(negedge clk);
    chk("R10 held bytes discarded by repeated start", wl_n - b0, 0);
  endtask

  task automatic t_read_wrap();
    logic k; logic [7:0] d;
    set_addr(16'h0FFE);
    bus_start(); wbyte(8'hAB, k);
    rbyte(1'b1, d); chk("R9 read at 0xFFE", d, pat(12'hFFE));
    rbyte(1'b1, d); chk("R9 read at 0xFFF", d, pat(12'hFFF));
    rbyte(1'b0, d); chk("R9 wrapped read at 0x000", d, pat(12'h000));
    bus_stop();
  endtask

  task automatic t_nak();
    logic k; logic [7:0] d;
    set_addr(16'h0010);
    bus_start(); wbyte(8'hAB, k);
    rbyte(1'b0, d); chk("R7 single read", d, pat(12'h010));
    chk("R8 line released after nak", sda_oe, 0);
    rbyte(1'b1, d); chk("R8 no data after nak", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_stop_idle();
    logic k;
    bus_start(); wbyte(8'hAA, k); chk("R3 ack before stop", k, 1);
    bus_stop();
    chk("R3 line released by stop", sda_oe, 0);
    wbyte(8'hAA, k); chk("R3 idle after stop ignores byte", k, 0);
    m_sda = 1'b1; hp(); m_scl = 1'b1; hp();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_no_start();
    m_sda = 1'b1; hp(); m_scl = 1'b1; hp();
    t_select();
    t_page_write();
    t_page_wrap();
    t_random_read();
    t_read_wrap();
    t_nak();
    t_stop_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule